// File: doc/BRIEF.md
# Masked Word Move Unit with Stepping Address Register

This block carries out one data move per strobe between a small set of word-wide registers (a comparand, two mask registers and a host output latch), a host input bus and an external word-addressed memory. A move always carries a whole word. When the move runs between memory and the comparand, one of the two mask registers can be selected. Only the bits where that mask holds 0 are changed in the destination.

The block keeps an address register for memory accesses. A move may name a memory location in one of two ways. The first uses the address register itself. The second uses an absolute address given with the command. In the absolute case, the address register is loaded from the command. After every memory move, the address register steps one location up or down, wrapping at the memory depth. Memory is read through a combinational read port on the same address that the write port presents. Writes carry a per-bit enable and an optional strobe that marks the location valid.

Select codes for both source and destination are: 0 comparand, 1 mask one, 2 mask two, 3 host (the source reads `host_wdata`, the destination loads `host_rdata`), 4 memory at the address register, 5 memory at the absolute address. Codes 6 and 7 are reserved. Mask select codes are: 0 none, 1 mask one, 2 mask two, 3 none.

Top module: `mdm_move_unit`

## Requirements
- R1: After reset, the address register, `host_rdata`, the comparand and both mask registers read 0.
- R2: A move whose source and destination are both codes 0–3 copies the full W-bit source word to the destination in the clock edge that samples `go`.
- R3: A move from memory (code 4 or 5) to the comparand with mask select 1 or 2 changes only the comparand bits whose mask bit is 0. With mask select 0 or 3, all bits are replaced.
- R4: A move from the comparand to memory drives `mem_wbe` as the inverse of the selected mask, or as all ones with no mask. Every other move to memory drives `mem_wbe` as all ones.
- R5: A move that names code 5 presents `abs_addr` on `mem_addr`. A move that names code 4 presents the address register.
- R6: After a memory move, the address register equals the used address plus 1 (`step_down`=0) or minus 1 (`step_down`=1), modulo DEPTH.
- R7: A move to memory asserts `mem_valid_we` in the same cycle as `mem_we` exactly when `set_valid` is 1. `mem_valid_we` is never high without `mem_we`.
- R8: A move whose source equals its destination changes no register, writes no memory and leaves the address register unchanged.
- R9: A move between codes 0–3 leaves the address register unchanged.
- R10: With `go` low, with a reserved code on either select, or with memory on both sides, nothing changes and `mem_we` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Execute one move this cycle |
| src_sel | input | 3 | Source code |
| dst_sel | input | 3 | Destination code |
| mask_sel | input | 2 | Mask select for comparand/memory moves |
| set_valid | input | 1 | Mark destination memory location valid |
| abs_addr | input | AW | Absolute memory address |
| step_down | input | 1 | 1: address steps down, 0: up |
| host_wdata | input | W | Host data source |
| mem_rdata | input | W | Memory read data at `mem_addr` |
| mem_addr | output | AW | Memory address for read and write |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | W | Memory write data |
| mem_wbe | output | W | Per-bit write enable |
| mem_valid_we | output | 1 | Set validity bit of addressed location |
| host_rdata | output | W | Host destination latch |
| addr_reg | output | AW | Current address register |

## Verification
A single memory move does three things in the same cycle: it loads the address from the command, it moves masked data, and it steps the address register. The bench provokes this with absolute-address moves at the top and bottom of a reduced-depth memory in both step directions. In the same cycle, it checks the write address and the bit enables against a behavioural model, then checks the wrapped address register after the edge. A second overlap is a register-only move issued between memory moves. There the bench checks that the address register holds while the data lands.

// File: rtl/mdm_move_unit.sv
module mdm_move_unit #(
  parameter int W     = 128,
  parameter int DEPTH = 1024,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    src_sel,
  input  logic [2:0]    dst_sel,
  input  logic [1:0]    mask_sel,
  input  logic          set_valid,
  input  logic [AW-1:0] abs_addr,
  input  logic          step_down,
  input  logic [W-1:0]  host_wdata,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [W-1:0]  mem_wdata,
  output logic [W-1:0]  mem_wbe,
  output logic          mem_valid_we,
  output logic [W-1:0]  host_rdata,
  output logic [AW-1:0] addr_reg
);

  localparam logic [2:0] SEL_CMP = 3'd0, SEL_MK1 = 3'd1, SEL_MK2 = 3'd2,
                         SEL_HOST = 3'd3, SEL_MAR = 3'd4, SEL_MABS = 3'd5;
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [W-1:0]  cmp_q, mk1_q, mk2_q, src_word, mask_vec;
  logic [AW-1:0] base, stepped;
  logic          src_ok, dst_ok, src_mem, dst_mem, act, mem_op, masked;

  assign src_ok  = src_sel <= SEL_MABS;
  assign dst_ok  = dst_sel <= SEL_MABS;
  assign src_mem = src_ok && src_sel >= SEL_MAR;
  assign dst_mem = dst_ok && dst_sel >= SEL_MAR;
  assign act     = go && src_ok && dst_ok && (src_sel != dst_sel) && !(src_mem && dst_mem);
  assign mem_op  = act && (src_mem || dst_mem);
  assign masked  = (src_mem && dst_sel == SEL_CMP) || (src_sel == SEL_CMP && dst_mem);

  assign base     = (src_sel == SEL_MABS || dst_sel == SEL_MABS) ? abs_addr : addr_reg;
  assign mem_addr = base;
  assign stepped  = step_down ? ((base == '0) ? TOP : base - 1'b1)
                              : ((base == TOP) ? '0 : base + 1'b1);

  always_comb begin
    case (src_sel)
      SEL_CMP:  src_word = cmp_q;
      SEL_MK1:  src_word = mk1_q;
      SEL_MK2:  src_word = mk2_q;
      SEL_HOST: src_word = host_wdata;
      default:  src_word = mem_rdata;
    endcase
  end

  always_comb begin
    mask_vec = '0;
    if (masked && mask_sel == 2'd1) mask_vec = mk1_q;
    if (masked && mask_sel == 2'd2) mask_vec = mk2_q;
  end

  assign mem_we       = act && dst_mem;
  assign mem_wdata    = src_word;
  assign mem_wbe      = ~mask_vec;
  assign mem_valid_we = mem_we && set_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q      <= '0;
      mk1_q      <= '0;
      mk2_q      <= '0;
      host_rdata <= '0;
      addr_reg   <= '0;
    end else begin
      if (act && dst_sel == SEL_CMP)  cmp_q <= (cmp_q & mask_vec) | (src_word & ~mask_vec);
      if (act && dst_sel == SEL_MK1)  mk1_q <= src_word;
      if (act && dst_sel == SEL_MK2)  mk2_q <= src_word;
      if (act && dst_sel == SEL_HOST) host_rdata <= src_word;
      if (mem_op) addr_reg <= stepped;
    end
  end

endmodule

module mdm_move_unit_chk #(
  parameter int W  = 128,
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [2:0]    src_sel,
  input logic [2:0]    dst_sel,
  input logic [1:0]    mask_sel,
  input logic [AW-1:0] abs_addr,
  input logic [AW-1:0] addr_reg,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic [W-1:0]  mem_wbe,
  input logic          mem_valid_we
);
  a_r7_valid_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_we |-> mem_we);
  a_r8_same_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (go && src_sel == dst_sel) |-> !mem_we);
  a_r8_same_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (go && src_sel == dst_sel) |=> $stable(addr_reg));
  a_r9_regreg_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (go && src_sel < 3'd4 && dst_sel < 3'd4) |=> $stable(addr_reg));
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!go || src_sel > 3'd5 || dst_sel > 3'd5) |-> !mem_we);
  a_r10_idle_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> $stable(addr_reg));
  a_r5_abs_address: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && dst_sel == 3'd5) |-> mem_addr == abs_addr);
  a_r4_full_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (src_sel != 3'd0 || mask_sel == 2'd0 || mask_sel == 2'd3)) |-> (&mem_wbe));
endmodule

bind mdm_move_unit mdm_move_unit_chk #(.W(W), .AW(AW)) chk_i (.*);

// File: tb/mdm_move_unit_tb.sv
module mdm_move_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 128;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0, go = 0, set_valid = 0, step_down = 0;
  logic [2:0] src_sel = 0, dst_sel = 0;
  logic [1:0] mask_sel = 0;
  logic [AW-1:0] abs_addr = 0;
  logic [W-1:0] host_wdata = 0, mem_rdata;
  logic [AW-1:0] mem_addr, addr_reg;
  logic mem_we, mem_valid_we;
  logic [W-1:0] mem_wdata, mem_wbe, host_rdata;

  logic [W-1:0] bmem [DEPTH];
  logic         bval [DEPTH];
  logic [W-1:0] m_reg [4];
  int           m_ar;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_rdata = bmem[mem_addr];

  mdm_move_unit #(.W(W), .DEPTH(DEPTH)) dut_i (.*);

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(int i);
    return {4{32'h9E37_79B9 * (i + 1) ^ 32'h5A5A_0000}};
  endfunction

  task automatic op(bit g, int s, int d, int ms, bit sv, int ab, bit dn, logic [W-1:0] hw);
    bit ok, sm, dm, act, msk;
    int used, nxt;
    logic [W-1:0] sw, mv;
    @(negedge clk);
    go = g; src_sel = 3'(s); dst_sel = 3'(d); mask_sel = 2'(ms);
    set_valid = sv; abs_addr = AW'(ab); step_down = dn; host_wdata = hw;
    ok = (s <= 5) && (d <= 5);
    sm = ok && s >= 4; dm = ok && d >= 4;
    act = g && ok && s != d && !(sm && dm);
    used = (s == 5 || d == 5) ? ab : m_ar;
    if (s <= 2) sw = m_reg[s]; else if (s == 3) sw = hw; else sw = bmem[used];
    msk = (sm && d == 0) || (s == 0 && dm);
    mv = '0;
    if (msk && ms == 1) mv = m_reg[1];
    if (msk && ms == 2) mv = m_reg[2];
    #1;
    chk("R10", "mem_we", W'(mem_we), W'(act && dm));
    chk("R7", "mem_valid_we", W'(mem_valid_we), W'(act && dm && sv));
    if (act && (sm || dm)) chk("R5", "mem_addr", W'(mem_addr), W'(used));
    if (act && dm) begin
      chk("R4", "mem_wbe", mem_wbe, ~mv);
      chk("R2", "mem_wdata", mem_wdata, sw);
    end
    @(posedge clk);
    if (act) begin
      if (d == 0) m_reg[0] = (m_reg[0] & mv) | (sw & ~mv);
      else if (d <= 3) m_reg[d] = sw;
      else begin
        bmem[used] = sw;
        if (sv) bval[used] = 1'b1;
      end
      if (sm || dm) begin
        nxt = dn ? used - 1 : used + 1;
        m_ar = (nxt + DEPTH) % DEPTH;
      end
    end
    #1;
    chk(act && (sm || dm) ? "R6" : "R9", "addr_reg", W'(addr_reg), W'(m_ar));
    chk("R2", "host_rdata", host_rdata, m_reg[3]);
    go = 0;
  endtask

  task automatic peek(int r, string req);
    op(1, r, 3, 0, 0, 0, 0, '0);
    chk(req, "register via host", host_rdata, m_reg[r]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b;
    for (int i = 0; i < DEPTH; i++) begin bmem[i] = pat(i); bval[i] = 0; end
    for (int i = 0; i < 4; i++) m_reg[i] = '0;
    m_ar = 0;
    #(CLK_PERIOD * 2 + 3);
    chk("R1", "addr_reg", W'(addr_reg), '0);
    chk("R1", "host_rdata", host_rdata, '0);
    rst_n = 1;
    peek(0, "R1"); peek(1, "R1"); peek(2, "R1");
    a = {32'hDEAD_BEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'hF0F0_0F0F};
    b = {64'hFFFF_0000_FFFF_0000, 64'h00FF_00FF_00FF_00FF};
    op(1, 3, 0, 0, 0, 0, 0, a); peek(0, "R2");
    op(1, 3, 1, 0, 0, 0, 0, b); peek(1, "R2");
    op(1, 3, 2, 0, 0, 0, 0, ~b); peek(2, "R2");
    op(1, 1, 0, 1, 0, 0, 0, '0); peek(0, "R2");
    op(1, 3, 0, 0, 0, 0, 0, a);
    op(1, 0, 5, 0, 1, DEPTH - 1, 0, '0);
    chk("R6", "wrap up to 0", W'(addr_reg), '0);
    op(1, 0, 5, 1, 0, 0, 1, '0);
    chk("R6", "wrap down to top", W'(addr_reg), W'(DEPTH - 1));
    op(1, 0, 4, 2, 1, 0, 1, '0);
    op(1, 4, 0, 1, 0, 0, 0, '0); peek(0, "R3");
    op(1, 5, 0, 2, 0, 7, 0, '0); peek(0, "R3");
    op(1, 5, 0, 3, 0, 3, 1, '0); peek(0, "R3");
    op(1, 2, 5, 1, 1, 9, 0, '0);
    op(1, 0, 0, 1, 1, 4, 0, '0); peek(0, "R8");
    op(1, 4, 4, 0, 1, 4, 0, '0);
    op(1, 4, 5, 0, 1, 4, 0, '0);
    op(1, 6, 0, 0, 0, 2, 0, '0); peek(0, "R10");
    op(1, 3, 7, 0, 1, 2, 0, a);
    op(0, 3, 5, 0, 1, 2, 0, a); peek(0, "R10");
    for (int k = 0; k < 300; k++)
      op($urandom_range(0, 7) != 0, $urandom_range(0, 7), $urandom_range(0, 7),
         $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, DEPTH - 1),
         $urandom_range(0, 1), {$urandom, $urandom, $urandom, $urandom});
    for (int r = 0; r < 3; r++) peek(r, "R2");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule